// File: doc/BRIEF.md
# Status word flag unit

This block keeps the processor's 8-bit status word. It also works out the arithmetic flags for byte-wide add and subtract operations that the core issues. The core supplies two operands, a carry-in and an operation select. The sum or difference is returned combinationally. When the flag-update enable is high, the carry, half carry and overflow flags that the operation produces are stored at the next clock edge.

The same word holds a user flag and the two register-bank select bits. Software loads them through a direct write port, and the current bank is also driven out on its own pins. The parity bit is not stored. It follows the accumulator input at all times, so it is always in step with the accumulator contents.

Top module: `flag_word_unit`

## Requirements
- R1: While reset is asserted and after its release, every stored bit of the status word is 0, and the bank select reads 0.
- R2: The status word layout, bit 7 down to bit 0, is: carry, half carry, user flag, bank select high, bank select low, overflow, reserved, parity. The reserved bit (bit 1) always reads 0.
- R3: With opSel = 0 the result is opA + opB + carryIn modulo 256. With opSel = 1 the result is opA - opB - carryIn modulo 256. The result is combinational.
- R4: The carry flag (bit 7) takes the carry out of bit 7 on an add, and the borrow out of bit 7 on a subtract.
- R5: The half carry flag (bit 6) takes the carry from bit 3 into bit 4 on an add, and the borrow from bit 4 into bit 3 on a subtract.
- R6: The overflow flag (bit 2) is 1 exactly when the signed result of the operation lies outside -128 to +127. On an add this equals the carry into bit 7 XOR the carry out of bit 7.
- R7: The parity bit (bit 0) makes the count of 1 bits in accIn plus the parity bit even. It changes combinationally with accIn.
- R8: Carry, half carry and overflow change only at a clock edge where flagUpdEn is high. An arithmetic update never changes the user flag or the bank bits.
- R9: A clock edge with wrEn high loads bits 7..2 of wrData into the status word. Bits 1 and 0 of wrData are ignored.
- R10: When wrEn and flagUpdEn are both high at the same edge, the direct write sets every stored bit and the arithmetic flags are discarded.
- R11: bankSel equals status word bits 4:3, with bit 4 as the MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opA | input | DATA_W | First operand (minuend) |
| opB | input | DATA_W | Second operand (subtrahend) |
| carryIn | input | 1 | Carry-in on add, borrow-in on subtract |
| opSel | input | 1 | 0 = add, 1 = subtract |
| flagUpdEn | input | 1 | Store the arithmetic flags at this edge |
| wrEn | input | 1 | Load the status word from wrData at this edge |
| wrData | input | 8 | Data for the direct write |
| accIn | input | DATA_W | Accumulator value used for parity |
| result | output | DATA_W | Sum or difference |
| statusWord | output | 8 | Status word |
| bankSel | output | 2 | Active register bank |

## Verification
The bench builds the block with its default DATA_W of 8. At that width the half carry boundary sits between bits 3 and 4, and the signed limits are -128 and +127. This means byte patterns such as 7F+01, 80-01, 0F+00 with carry-in, and 00-01 reach each flag's boundary exactly. A reference model scores every operation, including same-edge write and update collisions, all four bank codes, and a stream of pseudo-random operands, against the result, the word and the bank pins.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int WORD_W  = 8;
  localparam int POS_CY  = 7;
  localparam int POS_AC  = 6;
  localparam int POS_F0  = 5;
  localparam int POS_RS1 = 4;
  localparam int POS_RS0 = 3;
  localparam int POS_OV  = 2;
  localparam int POS_RSV = 1;
  localparam int POS_PAR = 0;

  // strobes from control to datapath
  typedef struct packed {
    logic loadArith;
    logic loadWord;
    logic subMode;
  } pswStrobes_t;

  typedef struct packed {
    logic cy;
    logic ac;
    logic ov;
  } arithFlags_t;
endpackage

// File: rtl/parity_tree.sv
module parity_tree #(
  parameter int W = 8
) (
  input  logic [W-1:0] bits,
  output logic         parity
);
  logic [W-1:0] runXor;

  assign runXor[0] = bits[0];
  for (genvar i = 1; i < W; i++) begin : g_xor
    assign runXor[i] = runXor[i-1] ^ bits[i];
  end

  // odd count of ones -> parity 1, making the total even
  assign parity = runXor[W-1];
endmodule

// File: rtl/psw_ctrl.sv
module psw_ctrl
  import psw_pkg::*;
(
  input  logic        flagUpdEn,
  input  logic        wrEn,
  input  logic        opSel,
  output pswStrobes_t strobes
);
  always_comb begin
    strobes.loadWord  = wrEn;
    // direct write has priority over arithmetic flag capture (R10)
    strobes.loadArith = flagUpdEn & ~wrEn;
    strobes.subMode   = opSel;
  end
endmodule

// File: rtl/psw_datapath.sv
module psw_datapath
  import psw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pswStrobes_t       strobes,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  input  logic [7:2]        wrField,
  output logic [DATA_W-1:0] result,
  output logic [7:2]        storedBits
);
  localparam int MSB    = DATA_W - 1;
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W:0]   chain;
  logic [DATA_W-1:0] bEff;
  arithFlags_t       flagsNext;

  logic       cyQ, acQ, f0Q, ovQ;
  logic [1:0] bankQ;

  // subtract is add of inverted subtrahend with inverted borrow-in
  assign bEff     = strobes.subMode ? ~opB : opB;
  assign chain[0] = strobes.subMode ? ~carryIn : carryIn;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign result[i]  = opA[i] ^ bEff[i] ^ chain[i];
    assign chain[i+1] = (opA[i] & bEff[i]) | (chain[i] & (opA[i] ^ bEff[i]));
  end

  always_comb begin
    flagsNext.cy = chain[DATA_W] ^ strobes.subMode;
    flagsNext.ac = chain[HALF_W] ^ strobes.subMode;
    flagsNext.ov = chain[DATA_W] ^ chain[MSB];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cyQ   <= 1'b0;
      acQ   <= 1'b0;
      f0Q   <= 1'b0;
      bankQ <= 2'b00;
      ovQ   <= 1'b0;
    end else if (strobes.loadWord) begin
      cyQ   <= wrField[POS_CY];
      acQ   <= wrField[POS_AC];
      f0Q   <= wrField[POS_F0];
      bankQ <= {wrField[POS_RS1], wrField[POS_RS0]};
      ovQ   <= wrField[POS_OV];
    end else if (strobes.loadArith) begin
      cyQ <= flagsNext.cy;
      acQ <= flagsNext.ac;
      ovQ <= flagsNext.ov;
    end
  end

  assign storedBits = {cyQ, acQ, f0Q, bankQ, ovQ};

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.loadArith || strobes.loadWord) |=> $stable(storedBits));

  p_user_bits_kept_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadArith |=> $stable({f0Q, bankQ}));

  p_write_lands_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadWord |=> storedBits == $past(wrField));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadArith && !strobes.subMode && (opA[MSB] != opB[MSB])) |=> !ovQ);

  p_sub_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadArith && strobes.subMode && (opA[MSB] == opB[MSB])) |=> !ovQ);
endmodule

// File: rtl/flag_word_unit.sv
module flag_word_unit
  import psw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  input  logic              opSel,
  input  logic              flagUpdEn,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  input  logic [DATA_W-1:0] accIn,
  output logic [DATA_W-1:0] result,
  output logic [7:0]        statusWord,
  output logic [1:0]        bankSel
);
  pswStrobes_t strobes;
  logic [7:2]  storedBits;
  logic        parityBit;
  logic        unusedWrBits;

  // parity and reserved positions of the write data are ignored (R9)
  assign unusedWrBits = ^wrData[1:0];

  psw_ctrl i_ctrl (
    .flagUpdEn (flagUpdEn),
    .wrEn      (wrEn),
    .opSel     (opSel),
    .strobes   (strobes)
  );

  psw_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .opA        (opA),
    .opB        (opB),
    .carryIn    (carryIn),
    .wrField    (wrData[7:2]),
    .result     (result),
    .storedBits (storedBits)
  );

  parity_tree #(.W(DATA_W)) i_par (
    .bits   (accIn),
    .parity (parityBit)
  );

  assign statusWord = {storedBits, 1'b0, parityBit};
  assign bankSel    = storedBits[POS_RS1:POS_RS0];

  p_parity_even_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($countones({accIn, statusWord[POS_PAR]}) % 2) == 0);
endmodule

// File: tb/test_flag_word_unit.sv
`timescale 1ns/1ps
module test_flag_word_unit;
  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] opA, opB, wrData, accIn;
  logic       carryIn, opSel, flagUpdEn, wrEn;
  logic [7:0] result, statusWord;
  logic [1:0] bankSel;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] expWordQ[$];
  string      expTagQ[$];

  // reference state
  logic mCy = 0, mAc = 0, mF0 = 0, mOv = 0;
  logic [1:0] mBank = 0;

  always #10 clk = ~clk;

  flag_word_unit i_flag_word_unit (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .carryIn(carryIn),
    .opSel(opSel), .flagUpdEn(flagUpdEn), .wrEn(wrEn), .wrData(wrData),
    .accIn(accIn), .result(result), .statusWord(statusWord), .bankSel(bankSel)
  );

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int sgn(logic [7:0] v);
    return (v >= 128) ? int'(v) - 256 : int'(v);
  endfunction

  // monitor: pops expected words shortly after each edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      while (expWordQ.size() > 0) begin
        logic [7:0] w;
        string t;
        w = expWordQ.pop_front();
        t = expTagQ.pop_front();
        check8({t, " word"}, statusWord, w);
        check8("R11 bank", {6'b0, bankSel}, {6'b0, w[4:3]});
      end
    end
  end

  task automatic doOp(logic [7:0] a, logic [7:0] b, logic cin, logic sub,
                      logic upd, logic wr, logic [7:0] wd, logic [7:0] acc, string tag);
    int full, nib, s;
    logic eCy, eAc, eOv;
    @(negedge clk);
    opA = a; opB = b; carryIn = cin; opSel = sub;
    flagUpdEn = upd; wrEn = wr; wrData = wd; accIn = acc;
    if (!sub) begin
      full = int'(a) + int'(b) + int'(cin);
      nib  = int'(a[3:0]) + int'(b[3:0]) + int'(cin);
      s    = sgn(a) + sgn(b) + int'(cin);
      eCy  = full > 255;
      eAc  = nib > 15;
    end else begin
      full = int'(a) - int'(b) - int'(cin);
      nib  = int'(a[3:0]) - int'(b[3:0]) - int'(cin);
      s    = sgn(a) - sgn(b) - int'(cin);
      eCy  = full < 0;
      eAc  = nib < 0;
    end
    eOv = (s > 127) || (s < -128);
    #2;
    check8("R3 result", result, full[7:0]);
    check8("R7 parity", {7'b0, statusWord[0]}, {7'b0, ^acc});
    @(posedge clk);
    #1;
    if (wr) begin
      mCy = wd[7]; mAc = wd[6]; mF0 = wd[5]; mBank = wd[4:3]; mOv = wd[2];
    end else if (upd) begin
      mCy = eCy; mAc = eAc; mOv = eOv;
    end
    expWordQ.push_back({mCy, mAc, mF0, mBank, mOv, 1'b0, ^acc});
    expTagQ.push_back(tag);
  endtask

  initial begin
    #(20 * 20000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    rstN = 0; opA = 0; opB = 0; carryIn = 0; opSel = 0;
    flagUpdEn = 1; wrEn = 1; wrData = 8'hFF; accIn = 8'h03;
    repeat (3) @(posedge clk);
    #5;
    check8("R1 reset word", statusWord, 8'h00);
    check8("R1 reset bank", {6'b0, bankSel}, 8'h00);
    @(negedge clk);
    accIn = 8'h01; flagUpdEn = 0; wrEn = 0;
    #2;
    check8("R7 parity in reset", {7'b0, statusWord[0]}, 8'h01);
    @(negedge clk);
    rstN = 1;
    @(posedge clk); #5;
    check8("R1 after release", statusWord, 8'h01);

    doOp(8'h7F, 8'h01, 0, 0, 1, 0, 8'h00, 8'h80, "R6");
    doOp(8'hFF, 8'h01, 0, 0, 1, 0, 8'h00, 8'h00, "R4");
    doOp(8'h0F, 8'h00, 1, 0, 1, 0, 8'h00, 8'h10, "R5");
    doOp(8'h80, 8'h80, 0, 0, 1, 0, 8'h00, 8'h07, "R6");
    doOp(8'h00, 8'h01, 0, 1, 1, 0, 8'h00, 8'hFF, "R4");
    doOp(8'h80, 8'h01, 0, 1, 1, 0, 8'h00, 8'h7F, "R6");
    doOp(8'h10, 8'h01, 0, 1, 1, 0, 8'h00, 8'h0F, "R5");
    doOp(8'h05, 8'h04, 1, 1, 1, 0, 8'h00, 8'h00, "R3");
    doOp(8'h7F, 8'hFF, 0, 1, 1, 0, 8'h00, 8'h01, "R6");
    // direct write: low two bits ignored, reserved reads 0
    doOp(8'h00, 8'h00, 0, 0, 0, 1, 8'hFF, 8'h00, "R9");
    doOp(8'h00, 8'h00, 0, 0, 0, 1, 8'h03, 8'h01, "R2");
    doOp(8'h00, 8'h00, 0, 0, 0, 1, 8'hFC, 8'h00, "R9");
    // no update enable: flags held despite an overflowing add
    doOp(8'h7F, 8'h7F, 1, 0, 0, 0, 8'h00, 8'h00, "R8");
    // arithmetic update keeps user flag and bank bits
    doOp(8'h01, 8'h01, 0, 0, 1, 0, 8'h00, 8'h00, "R8");
    // write and update at the same edge: write wins
    doOp(8'hFF, 8'h01, 0, 0, 1, 1, 8'h08, 8'h00, "R10");
    doOp(8'h00, 8'h00, 0, 0, 0, 1, 8'h10, 8'h00, "R11");
    doOp(8'h00, 8'h00, 0, 0, 0, 1, 8'h18, 8'h00, "R11");
    doOp(8'h7F, 8'h01, 0, 0, 1, 1, 8'h20, 8'h55, "R10");

    lfsr = 8'hA5;
    for (int i = 0; i < 48; i++) begin
      logic [7:0] a, b;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      a = lfsr;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      b = lfsr;
      doOp(a, b, b[0], a[1], (i % 5) != 0, (i % 11) == 3, a ^ b, a + b, "R3");
    end

    @(negedge clk);
    flagUpdEn = 0; wrEn = 0;
    repeat (3) @(posedge clk);
    #6;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule